// File: doc/BRIEF.md
# Kernel-Guarded Dual-Lookup Address Translation Buffer

This block is a small fully associative buffer that turns virtual page numbers into physical page numbers. Two lookup ports work side by side in every cycle: one serves the instruction fetch address and the other serves the load/store data address. Each port compares its page number against every stored entry combinationally. It returns a hit flag, a miss flag and the physical address in the same cycle. The low page-offset bits pass through unchanged.

A single update port changes the translation state. Through it, software can fill an entry at a chosen slot, drop one slot, flush every slot, or load a page-table base register. The port obeys only while the processor reports kernel mode. In user mode every request is refused, leaves the state untouched and raises a one-cycle fault pulse. A miss is only reported, and nothing here walks page tables.

Top module: `xlate_buffer`

## Requirements
- R1: After reset no entry is valid, the page-table base reads 0 and the fault output is 0, so both ports miss.
- R2: With kernel_mode=1 and upd_op=1 (fill), the slot at upd_slot takes upd_vpn and upd_ppn and becomes valid at the clock edge. From the next cycle, a lookup of that page hits with physical address {ppn, offset}, where the offset is the low 12 address bits passed through.
- R3: The fetch and data ports translate independently in the same cycle, each against the full table.
- R4: A lookup matching no valid entry gives hit=0, miss=1 and a physical address of 0; a hit gives hit=1, miss=0.
- R5: With kernel_mode=0, any nonzero upd_op is refused, changes no entry and not the base register. fault is 1 for exactly the one cycle after the refused request. Codes 5 to 7 in kernel mode do nothing and raise no fault.
- R6: upd_op=4 with kernel_mode=1 loads base_wdata into the page-table base output at the clock edge; no other case changes it.
- R7: upd_op=2 (drop) with kernel_mode=1 clears the valid bit of the slot at upd_slot only.
- R8: upd_op=3 (flush) with kernel_mode=1 clears every valid bit in one cycle.
- R9: Several valid entries may hold the same physical page number, and each translates to it.
- R10: When several valid entries hold the same virtual page, the lowest-numbered slot supplies the translation.
- R11: A lookup in the same cycle as an update sees the contents from before the update.
- R12: A fill of an occupied slot replaces it, so the previous virtual page no longer hits through that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kernel_mode | input | 1 | 1 when the processor runs privileged code |
| upd_op | input | 3 | Update code: 0 idle, 1 fill, 2 drop, 3 flush, 4 base load |
| upd_slot | input | 4 | Target slot for fill and drop |
| upd_vpn | input | 20 | Virtual page number for a fill |
| upd_ppn | input | 20 | Physical page number for a fill |
| base_wdata | input | 32 | Value for a base load |
| fetch_vaddr | input | 32 | Instruction fetch virtual address |
| fetch_hit | output | 1 | Fetch port found a translation |
| fetch_miss | output | 1 | Fetch port found none |
| fetch_paddr | output | 32 | Fetch physical address |
| data_vaddr | input | 32 | Load/store virtual address |
| data_hit | output | 1 | Data port found a translation |
| data_miss | output | 1 | Data port found none |
| data_paddr | output | 32 | Data physical address |
| pt_base | output | 32 | Page-table base register |
| fault | output | 1 | One-cycle pulse after a refused user-mode update |

## Verification
The assertions watch several rules on every cycle. A refused request leaves the valid bits and the base register stable and is followed by exactly one fault cycle. An accepted fill or drop sets or clears the targeted valid bit, and a flush empties the table. The base register moves only after an accepted base load. The slot selection never picks more than one entry, and the offset of a hit passes through unchanged. The directed scenarios cover what needs known data. These are the exact physical addresses, the lowest-slot choice among duplicate virtual pages, shared physical pages, an overwrite that removes the old mapping, and a lookup that still sees old contents during an update in the same cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Update request codes on the single write port.
  typedef enum logic [2:0] {
    XOP_IDLE  = 3'd0,
    XOP_FILL  = 3'd1,
    XOP_DROP  = 3'd2,
    XOP_FLUSH = 3'd3,
    XOP_BASE  = 3'd4
  } xlate_op_e;

endpackage

// File: rtl/xlate_priv_gate.sv
module xlate_priv_gate
  import xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kernel_mode,
  input  logic [2:0] op,
  output logic       acc_fill,
  output logic       acc_drop,
  output logic       acc_flush,
  output logic       acc_base,
  output logic       reject,
  output logic       fault
);

  xlate_op_e op_e;
  logic      fault_q;

  always_comb begin
    op_e      = xlate_op_e'(op);
    acc_fill  = kernel_mode && (op_e == XOP_FILL);
    acc_drop  = kernel_mode && (op_e == XOP_DROP);
    acc_flush = kernel_mode && (op_e == XOP_FLUSH);
    acc_base  = kernel_mode && (op_e == XOP_BASE);
    reject    = !kernel_mode && (op_e != XOP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= reject;
  end

  assign fault = fault_q;

  // R5: a refused request is followed by the fault pulse
  assert_fault_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> fault);
  // R5: fault lasts one cycle unless a new refusal arrived
  assert_fault_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reject |=> !fault);

endmodule

// File: rtl/xlate_entry_array.sv
module xlate_entry_array #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PTB_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc_fill,
  input  logic                            acc_drop,
  input  logic                            acc_flush,
  input  logic                            acc_base,
  input  logic                            reject,
  input  logic [IDX_W-1:0]                slot,
  input  logic [VPN_W-1:0]                new_vpn,
  input  logic [PPN_W-1:0]                new_ppn,
  input  logic [PTB_W-1:0]                base_wdata,
  output logic [ENTRIES-1:0]              valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_tab,
  output logic [PTB_W-1:0]                pt_base
);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [PTB_W-1:0]              base_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic hit_slot;
    assign hit_slot = (slot == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (acc_flush) begin
        valid_q[g] <= 1'b0;
      end else if (acc_fill && hit_slot) begin
        valid_q[g] <= 1'b1;
      end else if (acc_drop && hit_slot) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (acc_fill && hit_slot) begin
        vpn_q[g] <= new_vpn;
        ppn_q[g] <= new_ppn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (acc_base) base_q <= base_wdata;
  end

  assign valid   = valid_q;
  assign vpn_tab = vpn_q;
  assign ppn_tab = ppn_q;
  assign pt_base = base_q;

  // R5: refused requests leave translation state alone
  assert_user_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(valid_q) && $stable(base_q)));
  // R2: accepted fill marks its slot valid
  assert_fill_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fill |=> valid_q[$past(slot)]);
  // R7: accepted drop clears its slot
  assert_drop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> !valid_q[$past(slot)]);
  // R8: flush empties the table in one cycle
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_flush |=> (valid_q == '0));
  // R6: base register moves only on an accepted base load
  assert_base_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_base |=> $stable(base_q));

endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
  input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab,
  input  logic [VA_W-1:0]               vaddr,
  output logic                          hit,
  output logic                          miss,
  output logic [PA_W-1:0]               paddr
);

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PPN_W-1:0] p,
                                                input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] sel;
  logic [PPN_W-1:0]   sel_ppn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (vpn_tab[g] == page_of(vaddr));
  end

  // Lowest matching slot wins: scan downward so the last write is the lowest.
  always_comb begin
    sel     = '0;
    sel_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel     = '0;
        sel[i]  = 1'b1;
        sel_ppn = ppn_tab[i];
      end
    end
  end

  assign hit   = |match;
  assign miss  = !hit;
  assign paddr = hit ? join_addr(sel_ppn, offset_of(vaddr)) : '0;

  always_comb begin
    // R10: at most one slot feeds the translation
    assert_single_select_R10: assert ($onehot0(sel));
    // R2: the page offset passes through untouched on a hit
    if (hit) assert_offset_passthru_R2: assert (paddr[OFF_W-1:0] == vaddr[OFF_W-1:0]);
  end

endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PTB_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kernel_mode,
  input  logic [2:0]       upd_op,
  input  logic [IDX_W-1:0] upd_slot,
  input  logic [VPN_W-1:0] upd_vpn,
  input  logic [PPN_W-1:0] upd_ppn,
  input  logic [PTB_W-1:0] base_wdata,
  input  logic [VA_W-1:0]  fetch_vaddr,
  output logic             fetch_hit,
  output logic             fetch_miss,
  output logic [PA_W-1:0]  fetch_paddr,
  input  logic [VA_W-1:0]  data_vaddr,
  output logic             data_hit,
  output logic             data_miss,
  output logic [PA_W-1:0]  data_paddr,
  output logic [PTB_W-1:0] pt_base,
  output logic             fault
);

  logic acc_fill, acc_drop, acc_flush, acc_base, reject;
  logic [ENTRIES-1:0]            valid;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab;

  xlate_priv_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .kernel_mode(kernel_mode),
    .op         (upd_op),
    .acc_fill   (acc_fill),
    .acc_drop   (acc_drop),
    .acc_flush  (acc_flush),
    .acc_base   (acc_base),
    .reject     (reject),
    .fault      (fault)
  );

  xlate_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PTB_W(PTB_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fill  (acc_fill),
    .acc_drop  (acc_drop),
    .acc_flush (acc_flush),
    .acc_base  (acc_base),
    .reject    (reject),
    .slot      (upd_slot),
    .new_vpn   (upd_vpn),
    .new_ppn   (upd_ppn),
    .base_wdata(base_wdata),
    .valid     (valid),
    .vpn_tab   (vpn_tab),
    .ppn_tab   (ppn_tab),
    .pt_base   (pt_base)
  );

  // R3: two identical lookup engines share the table
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [VA_W-1:0] va;
    logic            h, m;
    logic [PA_W-1:0] pa;

    assign va = (p == 0) ? fetch_vaddr : data_vaddr;

    xlate_lookup #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
    ) u_look (
      .valid  (valid),
      .vpn_tab(vpn_tab),
      .ppn_tab(ppn_tab),
      .vaddr  (va),
      .hit    (h),
      .miss   (m),
      .paddr  (pa)
    );
  end

  assign fetch_hit   = g_port[0].h;
  assign fetch_miss  = g_port[0].m;
  assign fetch_paddr = g_port[0].pa;
  assign data_hit    = g_port[1].h;
  assign data_miss   = g_port[1].m;
  assign data_paddr  = g_port[1].pa;

endmodule

// File: tb/xlate_buffer_bench.sv
module xlate_buffer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel_mode = 1'b0;
  logic [2:0]  upd_op = 3'd0;
  logic [3:0]  upd_slot = '0;
  logic [19:0] upd_vpn = '0;
  logic [19:0] upd_ppn = '0;
  logic [31:0] base_wdata = '0;
  logic [31:0] fetch_vaddr = '0;
  logic [31:0] data_vaddr = '0;
  logic        fetch_hit, fetch_miss, data_hit, data_miss, fault;
  logic [31:0] fetch_paddr, data_paddr, pt_base;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlate_buffer u_xlate_buffer (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
    .upd_op(upd_op), .upd_slot(upd_slot), .upd_vpn(upd_vpn),
    .upd_ppn(upd_ppn), .base_wdata(base_wdata),
    .fetch_vaddr(fetch_vaddr), .fetch_hit(fetch_hit),
    .fetch_miss(fetch_miss), .fetch_paddr(fetch_paddr),
    .data_vaddr(data_vaddr), .data_hit(data_hit),
    .data_miss(data_miss), .data_paddr(data_paddr),
    .pt_base(pt_base), .fault(fault)
  );

  function automatic logic [31:0] expect_pa(input logic [19:0] ppn,
                                            input logic [31:0] va);
    return {ppn, va[11:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one update for one clock edge; returns at the following negedge.
  task automatic upd(input logic kern, input logic [2:0] op, input logic [3:0] slot,
                     input logic [19:0] vpn, input logic [19:0] ppn,
                     input logic [31:0] bw);
    @(negedge clk);
    kernel_mode = kern; upd_op = op; upd_slot = slot;
    upd_vpn = vpn; upd_ppn = ppn; base_wdata = bw;
    @(negedge clk);
    upd_op = 3'd0;
  endtask

  // Look up on one port; exp_ppn ignored when a miss is expected.
  task automatic probe_f(input string req, input logic [31:0] va,
                         input logic exp_hit, input logic [19:0] exp_ppn);
    fetch_vaddr = va;
    #2;
    chk({req, " fetch hit"},  32'(fetch_hit),  32'(exp_hit));
    chk({req, " fetch miss"}, 32'(fetch_miss), 32'(!exp_hit));
    chk({req, " fetch paddr"}, fetch_paddr, exp_hit ? expect_pa(exp_ppn, va) : 32'h0);
  endtask

  task automatic probe_d(input string req, input logic [31:0] va,
                         input logic exp_hit, input logic [19:0] exp_ppn);
    data_vaddr = va;
    #2;
    chk({req, " data hit"},  32'(data_hit),  32'(exp_hit));
    chk({req, " data miss"}, 32'(data_miss), 32'(!exp_hit));
    chk({req, " data paddr"}, data_paddr, exp_hit ? expect_pa(exp_ppn, va) : 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 base", pt_base, 32'h0);
    chk("R1 fault", 32'(fault), 32'h0);
    probe_f("R1", 32'h0000_0000, 1'b0, '0);
    probe_d("R4", 32'h1234_5678, 1'b0, '0);
  endtask

  task automatic t_fill_dual;
    upd(1'b1, 3'd1, 4'd3, 20'h12345, 20'hABCDE, '0);
    upd(1'b1, 3'd1, 4'd7, 20'h00042, 20'h00099, '0);
    fetch_vaddr = 32'h1234_5FFF;
    data_vaddr  = 32'h0004_2001;
    #2;
    chk("R3 fetch paddr", fetch_paddr, 32'hABCD_EFFF);
    chk("R3 data paddr",  data_paddr,  32'h0009_9001);
    chk("R3 both hit", 32'({fetch_hit, data_hit}), 32'b11);
    probe_f("R2", 32'h1234_5678, 1'b1, 20'hABCDE);
  endtask

  task automatic t_shared_ppn;
    upd(1'b1, 3'd1, 4'd8, 20'h55555, 20'hABCDE, '0);
    probe_f("R9", 32'h5555_5010, 1'b1, 20'hABCDE);
    probe_d("R9", 32'h1234_5020, 1'b1, 20'hABCDE);
  endtask

  task automatic t_user_refused;
    upd(1'b0, 3'd1, 4'd3, 20'h77777, 20'h11111, '0);
    chk("R5 fault pulse", 32'(fault), 32'h1);
    @(negedge clk);
    chk("R5 fault clears", 32'(fault), 32'h0);
    probe_f("R5 no install", 32'h7777_7000, 1'b0, '0);
    probe_d("R5 slot kept", 32'h1234_5ABC, 1'b1, 20'hABCDE);
    upd(1'b0, 3'd4, 4'd0, '0, '0, 32'hDEAD_0000);
    chk("R5 base fault", 32'(fault), 32'h1);
    chk("R5 base kept", pt_base, 32'h0);
    upd(1'b0, 3'd3, 4'd0, '0, '0, '0);
    probe_f("R5 flush refused", 32'h0004_2002, 1'b1, 20'h00099);
    upd(1'b1, 3'd6, 4'd3, '0, '0, '0);
    chk("R5 undefined code no fault", 32'(fault), 32'h0);
    probe_d("R5 undefined code", 32'h1234_5000, 1'b1, 20'hABCDE);
  endtask

  task automatic t_base;
    upd(1'b1, 3'd4, 4'd0, '0, '0, 32'h0040_1000);
    chk("R6 base load", pt_base, 32'h0040_1000);
    chk("R6 no fault", 32'(fault), 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    kernel_mode = 1'b1; upd_op = 3'd1; upd_slot = 4'd10;
    upd_vpn = 20'h3C3C3; upd_ppn = 20'h00777;
    fetch_vaddr = 32'h3C3C_3000;
    #2;
    chk("R11 old view hit", 32'(fetch_hit), 32'h0);
    @(negedge clk);
    upd_op = 3'd0;
    probe_f("R11 after edge", 32'h3C3C_3000, 1'b1, 20'h00777);
  endtask

  task automatic t_overwrite;
    upd(1'b1, 3'd1, 4'd3, 20'h24680, 20'h13579, '0);
    probe_f("R12 old gone", 32'h1234_5000, 1'b0, '0);
    probe_d("R12 new", 32'h2468_0ABC, 1'b1, 20'h13579);
  endtask

  task automatic t_priority_and_drop;
    upd(1'b1, 3'd1, 4'd12, 20'h0ABCD, 20'h00012, '0);
    upd(1'b1, 3'd1, 4'd5,  20'h0ABCD, 20'h00034, '0);
    probe_f("R10 lowest slot", 32'h0ABC_D111, 1'b1, 20'h00034);
    upd(1'b1, 3'd2, 4'd5, '0, '0, '0);
    probe_d("R7 dropped slot", 32'h0ABC_D222, 1'b1, 20'h00012);
    probe_f("R7 others kept", 32'h2468_0000, 1'b1, 20'h13579);
  endtask

  task automatic t_flush;
    upd(1'b1, 3'd3, 4'd0, '0, '0, '0);
    probe_f("R8 flush", 32'h2468_0000, 1'b0, '0);
    probe_d("R8 flush", 32'h0ABC_D000, 1'b0, '0);
    probe_f("R8 flush", 32'h5555_5000, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_dual();
    t_shared_ppn();
    t_user_refused();
    t_base();
    t_same_cycle();
    t_overwrite();
    t_priority_and_drop();
    t_flush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule